// File: doc/BRIEF.md
# Serial Bus Loopback Self-Test Monitor

This block checks a serial bus encoder/decoder path while it carries live traffic. Every word handed to the encoder is also offered to the monitor. The decoder's copy of the word, read back from the bus, comes in on a second stream. For every word the monitor checks the four validity flags the decoder reports: sync pattern, Manchester encoding, bit count and odd parity. For the word that closes a message, it also compares all 16 data bits against what was sent. A watchdog times how long the transmitter stays active. Its limit is set by a protocol-variant input, older (A) or newer (B).

At the end of each message the block gives a one-cycle done pulse and drives a loop-fail status bit that holds until the next message begins. If the interrupt is enabled, a failure also gives a one-cycle interrupt request, which sets a sticky interrupt status bit that the host clears.

Both data streams use valid/ready. The transmit side accepts one word and then deasserts ready until that word's echo arrives or its echo window expires, so an upstream encoder feeder stalls on back-pressure. The receive side never back-pressures, because decoder output cannot be held. Its ready is tied high.

Top module: `loopback_selftest_mon`

## Requirements
- R1: `tx_ready` is high whenever no word is awaiting its echo. It goes low in the cycle after a word is accepted (`tx_valid` and `tx_ready` both high). It stays low until that word's echo is accepted or its window expires. `rx_ready` is always high.
- R2: An echo with any of `rx_sync_ok`, `rx_manch_ok`, `rx_count_ok` or `rx_par_ok` low fails the message, whatever position the word holds in the message.
- R3: The echo of a word sent with `tx_last` = 1 must equal that word's `tx_data` in all 16 bits, or the message fails. A data mismatch on a word with `tx_last` = 0 does not fail the message.
- R4: If no echo arrives within ECHO_BITS*CYC_PER_BIT cycles after a word is accepted, that word counts as invalid, the message fails, and `tx_ready` returns high.
- R5: The watchdog fails the current message when `tx_active` stays high for the limit number of consecutive cycles. The limit is WDOG_LIM_B when `variant_b` = 1 and WDOG_LIM_A when `variant_b` = 0. Any cycle with `tx_active` low restarts the count.
- R6: `msg_done` pulses for one cycle, in the cycle after the last word's echo is accepted or its window expires. `loop_fail` is valid from that cycle on (1 = fail). It holds until the first word of the next message is accepted and reads 0 in the cycle after that.
- R7: `irq_req` pulses together with `msg_done` only when the message failed and `irq_en` was high. `irq_status` goes high one cycle after `irq_req` and stays high until `irq_clr`. A set and a clear in the same cycle leave it set.
- R8: An echo that arrives while no word is awaiting one is ignored. It produces no `msg_done` and does not affect the next message's result.
- R9: After reset, `tx_ready` = 1, `msg_done` = 0, `loop_fail` = 0, `irq_req` = 0 and `irq_status` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| variant_b | input | 1 | 1 selects the B watchdog limit, 0 the A limit |
| tx_active | input | 1 | Transmitter is driving the bus |
| irq_en | input | 1 | Enables the interrupt on loop-test failure |
| irq_clr | input | 1 | Clears the sticky interrupt status |
| tx_valid | input | 1 | Word offered to the encoder |
| tx_ready | output | 1 | Monitor can take a transmit word |
| tx_data | input | 16 | Transmitted data word |
| tx_last | input | 1 | Word closes the message |
| rx_valid | input | 1 | Decoded echo word present |
| rx_ready | output | 1 | Always 1 |
| rx_data | input | 16 | Decoded echo data |
| rx_sync_ok | input | 1 | Echo sync pattern correct |
| rx_manch_ok | input | 1 | Echo Manchester encoding valid |
| rx_count_ok | input | 1 | Echo bit count correct |
| rx_par_ok | input | 1 | Echo odd parity correct |
| msg_done | output | 1 | One-cycle end-of-message pulse |
| loop_fail | output | 1 | Loop-test fail bit of the block status |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_status | output | 1 | Sticky interrupt status |

## Verification
The bench sends clean messages of one and two words. In one of them the first word's echo carries wrong data, which shows that only the closing word is compared bit by bit. Each validity flag is then cleared on its own, so a missing term in the flag check shows up, and a corrupted last-word echo shows that the comparison covers the data. A silent echo window separates the timeout path from the echo path. One transmit burst longer than the A limit but shorter than the B limit, run under each variant, shows that the variant input picks the limit. A broken burst whose pieces stay below the A limit shows that the count restarts. Stray echoes with nothing in flight, and failures with the interrupt masked and unmasked, cover the ignore rule and the interrupt gating.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  typedef struct packed {
    logic sync_ok;
    logic manch_ok;
    logic count_ok;
    logic par_ok;
  } rx_flags_t;

  function automatic logic flags_good(rx_flags_t f);
    return f.sync_ok & f.manch_ok & f.count_ok & f.par_ok;
  endfunction
endpackage

// File: rtl/lbt_watchdog.sv
module lbt_watchdog #(
  parameter int LIM_A = 900,
  parameter int LIM_B = 33000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic variant_b,
  output logic trip
);
  localparam int LIM_MAX = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int CW      = $clog2(LIM_MAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = variant_b ? CW'(LIM_B) : CW'(LIM_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      trip <= 1'b0;
    end else begin
      trip <= 1'b0;
      if (!tx_active) begin
        cnt <= '0;
      end else if (cnt < limit) begin
        cnt <= cnt + 1'b1;
        if (cnt == limit - 1'b1) trip <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lbt_echo_check.sv
module lbt_echo_check
  import lbt_pkg::*;
#(
  parameter int W        = 16,
  parameter int ECHO_TMO = 1600
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_data,
  input  logic         tx_last,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  rx_flags_t    rx_flags,
  output logic         word_accept,
  output logic         resolve,
  output logic         resolve_bad,
  output logic         resolve_last
);
  localparam int TW = $clog2(ECHO_TMO + 1);

  logic          waiting;
  logic [TW-1:0] tmr;
  logic [W-1:0]  exp_q;
  logic          last_q;
  logic          tmo_hit;
  logic          mism;

  assign tx_ready     = !waiting;
  assign word_accept  = tx_valid && !waiting;
  assign tmo_hit      = waiting && (tmr == TW'(ECHO_TMO - 1));
  assign mism         = last_q && (rx_data != exp_q);
  assign resolve      = waiting && (rx_valid || tmo_hit);
  assign resolve_bad  = rx_valid ? (!flags_good(rx_flags) || mism) : 1'b1;
  assign resolve_last = last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      tmr     <= '0;
      exp_q   <= '0;
      last_q  <= 1'b0;
    end else if (word_accept) begin
      waiting <= 1'b1;
      tmr     <= '0;
      exp_q   <= tx_data;
      last_q  <= tx_last;
    end else if (resolve) begin
      waiting <= 1'b0;
    end else if (waiting) begin
      tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/lbt_result.sv
module lbt_result (
  input  logic clk,
  input  logic rst_n,
  input  logic word_accept,
  input  logic resolve,
  input  logic resolve_bad,
  input  logic resolve_last,
  input  logic wd_trip,
  input  logic irq_en,
  input  logic irq_clr,
  output logic msg_done,
  output logic loop_fail,
  output logic irq_req,
  output logic irq_status
);
  logic in_msg;
  logic acc;
  logic final_fail;

  assign final_fail = acc || wd_trip || resolve_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_msg    <= 1'b0;
      acc       <= 1'b0;
      msg_done  <= 1'b0;
      loop_fail <= 1'b0;
      irq_req   <= 1'b0;
    end else begin
      msg_done <= 1'b0;
      irq_req  <= 1'b0;
      if (word_accept && !in_msg) begin
        in_msg    <= 1'b1;
        acc       <= wd_trip;
        loop_fail <= 1'b0;
      end else if (resolve && resolve_last) begin
        in_msg    <= 1'b0;
        acc       <= 1'b0;
        msg_done  <= 1'b1;
        loop_fail <= final_fail;
        irq_req   <= final_fail && irq_en;
      end else begin
        acc <= acc || wd_trip || (resolve && resolve_bad);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_status <= 1'b0;
    else if (irq_req) irq_status <= 1'b1;
    else if (irq_clr) irq_status <= 1'b0;
  end
endmodule

// File: rtl/loopback_selftest_mon.sv
module loopback_selftest_mon
  import lbt_pkg::*;
#(
  parameter int W           = 16,
  parameter int CYC_PER_BIT = 50,
  parameter int ECHO_BITS   = 32,
  parameter int WDOG_LIM_A  = 900,
  parameter int WDOG_LIM_B  = 33000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         variant_b,
  input  logic         tx_active,
  input  logic         irq_en,
  input  logic         irq_clr,
  input  logic         tx_valid,
  output logic         tx_ready,
  input  logic [W-1:0] tx_data,
  input  logic         tx_last,
  input  logic         rx_valid,
  output logic         rx_ready,
  input  logic [W-1:0] rx_data,
  input  logic         rx_sync_ok,
  input  logic         rx_manch_ok,
  input  logic         rx_count_ok,
  input  logic         rx_par_ok,
  output logic         msg_done,
  output logic         loop_fail,
  output logic         irq_req,
  output logic         irq_status
);
  localparam int ECHO_TMO = ECHO_BITS * CYC_PER_BIT;

  rx_flags_t flags;
  logic word_accept, resolve, resolve_bad, resolve_last, wd_trip;

  assign flags    = '{sync_ok: rx_sync_ok, manch_ok: rx_manch_ok,
                      count_ok: rx_count_ok, par_ok: rx_par_ok};
  assign rx_ready = 1'b1;

  lbt_watchdog #(.LIM_A(WDOG_LIM_A), .LIM_B(WDOG_LIM_B)) u_wdog (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active),
    .variant_b(variant_b), .trip(wd_trip)
  );

  lbt_echo_check #(.W(W), .ECHO_TMO(ECHO_TMO)) u_echo (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_flags(flags), .word_accept(word_accept),
    .resolve(resolve), .resolve_bad(resolve_bad), .resolve_last(resolve_last)
  );

  lbt_result u_res (
    .clk(clk), .rst_n(rst_n), .word_accept(word_accept), .resolve(resolve),
    .resolve_bad(resolve_bad), .resolve_last(resolve_last), .wd_trip(wd_trip),
    .irq_en(irq_en), .irq_clr(irq_clr), .msg_done(msg_done),
    .loop_fail(loop_fail), .irq_req(irq_req), .irq_status(irq_status)
  );
endmodule

// File: rtl/lbt_sva.sv
module lbt_sva (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic msg_done,
  input logic loop_fail,
  input logic irq_en,
  input logic irq_req,
  input logic irq_status,
  input logic irq_clr
);
  p_ready_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> !msg_done);

  p_fail_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(loop_fail) |-> (msg_done || $past(tx_valid && tx_ready)));

  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (msg_done && loop_fail && $past(irq_en)));

  p_irq_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> irq_status);

  p_irq_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_status) |-> $past(irq_clr));
endmodule

bind loopback_selftest_mon lbt_sva u_sva (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .msg_done(msg_done), .loop_fail(loop_fail), .irq_en(irq_en),
  .irq_req(irq_req), .irq_status(irq_status), .irq_clr(irq_clr)
);

// File: tb/tb_loopback_selftest_mon.sv
module tb_loopback_selftest_mon;
  localparam int CPB = 25, EBITS = 24, TMO = CPB * EBITS;
  localparam int LA = 200, LB = 400;

  logic clk = 0, rst_n = 0;
  logic variant_b = 1, tx_active = 0, irq_en = 0, irq_clr = 0;
  logic tx_valid = 0, tx_last = 0, rx_valid = 0;
  logic [15:0] tx_data = '0, rx_data = '0;
  logic rx_sync_ok = 1, rx_manch_ok = 1, rx_count_ok = 1, rx_par_ok = 1;
  logic tx_ready, rx_ready, msg_done, loop_fail, irq_req, irq_status;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [1:0] expq[$];  // {fail, irq}

  always #10 clk = ~clk;

  loopback_selftest_mon #(.CYC_PER_BIT(CPB), .ECHO_BITS(EBITS),
    .WDOG_LIM_A(LA), .WDOG_LIM_B(LB)) dut (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected result at each msg_done
  always @(negedge clk) if (rst_n && msg_done) begin
    if (expq.size() == 0) chk(1'b0, "R8 unexpected msg_done", 1, 0);
    else begin
      logic [1:0] e;
      e = expq.pop_front();
      chk(loop_fail == e[1], "R6 loop_fail at done", loop_fail, e[1]);
      chk(irq_req == e[0], "R7 irq_req at done", irq_req, e[0]);
    end
  end

  task automatic send(input logic [15:0] d, input logic last);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1; tx_data = d; tx_last = last;
    @(negedge clk);
    tx_valid = 0; tx_last = 0;
  endtask

  task automatic echo(input logic [15:0] d, input logic [3:0] f);
    rx_valid = 1; rx_data = d;
    {rx_sync_ok, rx_manch_ok, rx_count_ok, rx_par_ok} = f;
    @(negedge clk);
    rx_valid = 0; {rx_sync_ok, rx_manch_ok, rx_count_ok, rx_par_ok} = 4'hF;
  endtask

  // one-word message, expected fail/irq pushed first
  task automatic one(input logic [15:0] d, input logic [15:0] e, input logic [3:0] f,
                     input logic xf);
    expq.push_back({xf, xf & irq_en});
    send(d, 1);
    echo(e, f);
    @(negedge clk);
  endtask

  task automatic burst(input int n);
    tx_active = 1;
    repeat (n) @(negedge clk);
    tx_active = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(tx_ready == 1, "R9 tx_ready", tx_ready, 1);
    chk(msg_done == 0 && irq_req == 0, "R9 pulses", msg_done | irq_req, 0);
    chk(loop_fail == 0, "R9 loop_fail", loop_fail, 0);
    chk(irq_status == 0, "R9 irq_status", irq_status, 0);
    rst_n = 1;
    @(negedge clk);
    chk(rx_ready == 1, "R1 rx_ready", rx_ready, 1);

    // R1 handshake and clean one-word pass
    expq.push_back(2'b00);
    send(16'hA5C3, 1);
    chk(tx_ready == 0, "R1 ready low while waiting", tx_ready, 0);
    repeat (5) @(negedge clk);
    chk(tx_ready == 0, "R1 ready still low", tx_ready, 0);
    echo(16'hA5C3, 4'hF);
    chk(tx_ready == 1, "R1 ready back after echo", tx_ready, 1);
    @(negedge clk);

    // R3 first-word mismatch ignored, two-word message passes
    expq.push_back(2'b00);
    send(16'h1111, 0); echo(16'h2222, 4'hF);
    send(16'h3333, 1); echo(16'h3333, 4'hF);
    @(negedge clk);

    // R3 last-word single-bit mismatch fails
    one(16'h8001, 16'h8000, 4'hF, 1);

    // R2 each flag alone, on a non-last word
    for (int i = 0; i < 4; i++) begin
      expq.push_back(2'b10);
      send(16'h0F0F, 0); echo(16'h0F0F, ~(4'b1 << i));
      send(16'h00FF, 1); echo(16'h00FF, 4'hF);
      @(negedge clk);
    end

    // R6 fail holds, clears on next start
    repeat (10) @(negedge clk);
    chk(loop_fail == 1, "R6 loop_fail held", loop_fail, 1);
    expq.push_back(2'b00);
    send(16'h4242, 1);
    chk(loop_fail == 0, "R6 cleared at next start", loop_fail, 0);
    echo(16'h4242, 4'hF);
    @(negedge clk);

    // R4 echo timeout
    expq.push_back(2'b10);
    send(16'h7777, 1);
    repeat (TMO - 2) @(negedge clk);
    chk(tx_ready == 0, "R4 ready low before timeout", tx_ready, 0);
    repeat (4) @(negedge clk);
    chk(tx_ready == 1, "R4 ready back after timeout", tx_ready, 1);
    chk(loop_fail == 1, "R4 timeout fail", loop_fail, 1);

    // R5 watchdog: burst 300 passes under B, fails under A
    variant_b = 1;
    expq.push_back(2'b00);
    send(16'h5555, 1); burst(300); echo(16'h5555, 4'hF); @(negedge clk);
    variant_b = 0;
    expq.push_back(2'b10);
    send(16'h5555, 1); burst(300); echo(16'h5555, 4'hF); @(negedge clk);
    // R5 broken bursts below A restart the count
    expq.push_back(2'b00);
    send(16'h6666, 1); burst(150); @(negedge clk); burst(150);
    echo(16'h6666, 4'hF); @(negedge clk);
    variant_b = 1;

    // R8 stray echoes ignored
    echo(16'hDEAD, 4'h0); echo(16'hBEEF, 4'hF);
    repeat (3) @(negedge clk);
    chk(loop_fail == 0, "R8 stray echo no effect", loop_fail, 0);
    one(16'h9999, 16'h9999, 4'hF, 0);

    // R7 interrupt masked, then enabled, then cleared
    irq_en = 0;
    one(16'h1234, 16'h1235, 4'hF, 1);
    chk(irq_status == 0, "R7 masked no status", irq_status, 0);
    irq_en = 1;
    one(16'h1234, 16'h1234, 4'h7, 1);
    chk(irq_status == 1, "R7 status set", irq_status, 1);
    one(16'h1234, 16'h1234, 4'hF, 0);
    chk(irq_status == 1, "R7 status sticky", irq_status, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk(irq_status == 0, "R7 status cleared", irq_status, 0);

    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R6 all messages done", expq.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule